// File: doc/BRIEF.md
# Multiword DMA Handshake Controller

This block sits on the host side of a parallel disk interface and moves 16-bit words between a local FIFO pair and the attached device in multiword DMA. Software-side logic gives it a word count and a direction, then pulses `start`. The controller waits for the device to raise its DMA request. It then answers with a DMA acknowledge and issues one timed strobe per word: a read strobe when data flows from the device to the host, and a write strobe when data flows from the host to the device.

The device paces the burst through its request line. While the request stays high, the controller keeps issuing strobes. When the request drops, the controller completes the strobe already under way, withdraws the acknowledge, and waits for the request to return. A request line that is low, or one the device has released, is treated as no request. Strobes are also held back while the local transmit FIFO is empty or the receive FIFO is full. When the programmed count is used up, the acknowledge drops and a done flag is raised. The done flag stays high until the next start.

Both chip selects stay inactive throughout, because this block performs only data transfers, and every transfer uses the full 16-bit width.

Top module: `mdma_ctrl`

## Requirements
- R1: After reset, `devAck`, `rdStrobe`, `wrStrobe`, `busy`, `done` and `busDataOe` are low, and both active-low chip selects `csCmdN` and `csCtlN` are high.
- R2: `devAck` rises only in a cycle directly after one in which `devReq` was sampled high.
- R3: Strobes occur only while `devAck` is high. `rdStrobe` is used when `dirRead`=1 was latched at start, `wrStrobe` when it was 0, and the two are never high together. Each strobe is high for exactly STROBE_CYC cycles, and consecutive strobes are separated by at least RECOV_CYC+1 low cycles.
- R4: `csCmdN` and `csCtlN` stay high at all times, including every cycle in which `devAck` is high.
- R5: In a host-to-device transfer, `busDataOe` is high exactly while `devAck` is high. During each write strobe, `busDataOut` carries the next 16-bit FIFO word, in FIFO order. In a device-to-host transfer, `busDataOe` stays low.
- R6: In a device-to-host transfer, the 16-bit `busDataIn` value present in the last cycle of each read strobe is pushed to the receive FIFO via `rxPush`/`rxData`, in order.
- R7: A strobe starts only if `devReq` was high in the cycle before. After `devReq` falls, `devAck` falls within STROBE_CYC+RECOV_CYC+2 cycles, and the transfer resumes once `devReq` returns.
- R8: No write strobe starts while `txEmpty` is high, and no read strobe starts while `rxFull` is high. `txPop` is raised only when `txEmpty` is low.
- R9: A transfer issues exactly `wordCount` strobes. It then leaves `devAck` low and `busy` low with `done` high, and `done` holds until the next accepted start. A `start` pulse received while `busy` is high is ignored.
- R10: A start with `wordCount`=0 sets `done` without ever raising `devAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| dirRead | input | 1 | 1 = device to host, 0 = host to device; latched at start |
| wordCount | input | CNT_W | Words to move; latched at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished; cleared by next start |
| devReq | input | 1 | Device DMA request |
| devAck | output | 1 | Host DMA acknowledge |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| csCmdN | output | 1 | Command-register chip select, active low, held inactive |
| csCtlN | output | 1 | Control-register chip select, active low, held inactive |
| busDataIn | input | DATA_W | Data from device |
| busDataOut | output | DATA_W | Data to device |
| busDataOe | output | 1 | Output enable for busDataOut |
| txData | input | DATA_W | Head word of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO empty |
| txPop | output | 1 | Consume the transmit FIFO head |
| rxData | output | DATA_W | Word for the receive FIFO |
| rxFull | input | 1 | Receive FIFO full |
| rxPush | output | 1 | Write rxData into the receive FIFO |

## Verification
The hardest case to reach is a request that drops while a strobe is in flight, combined with a FIFO that is not ready when the request returns. Both gates then decide the next strobe in the same cycle. The stimulus reaches this case with a device model that raises and drops its request at random, whenever it likes, during an acknowledged burst. The receive-full input is also toggled at random during reads. Directed runs add a mid-burst request withdrawal, a transmit FIFO starved after three words, and a receive FIFO held full from the start.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WREQ, S_ACK, S_STB, S_REC, S_FIN
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture count and direction
    logic decr;      // one word finished
    logic latchOut;  // capture transmit word
    logic tmrStb;    // arm timer for strobe phase
    logic tmrRec;    // arm timer for recovery phase
  } ctrl_t;
endpackage

// File: rtl/mdma_dp.sv
module mdma_dp
  import mdma_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              dirIn,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] outData,
  output logic              dirRead,
  output logic              cntZero,
  output logic              tmrDone
);
  localparam int TMR_MAX = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
  localparam int TMR_W   = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);
  localparam logic [TMR_W-1:0] STB_LD = TMR_W'(STROBE_CYC - 1);
  localparam logic [TMR_W-1:0] REC_LD = TMR_W'(RECOV_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      dirRead <= 1'b0;
      outData <= '0;
    end else begin
      if (ctrl.load) begin
        cnt     <= wordCount;
        dirRead <= dirIn;
      end else if (ctrl.decr) begin
        cnt <= cnt - 1'b1;
      end
      if (ctrl.latchOut) outData <= txData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tmr <= '0;
    else if (ctrl.tmrStb)  tmr <= STB_LD;
    else if (ctrl.tmrRec)  tmr <= REC_LD;
    else if (tmr != '0)    tmr <= tmr - 1'b1;
  end

  assign cntZero = (cnt == '0);
  assign tmrDone = (tmr == '0);

  // R9: each finished word lowers the remaining count by exactly one
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decr |=> (cnt == $past(cnt) - 1'b1));
  // R9: never finish a word when none remain
  p_no_decr_at_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decr |-> !cntZero);
endmodule

// File: rtl/mdma_fsm.sv
module mdma_fsm
  import mdma_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  devReq,
  input  logic  txEmpty,
  input  logic  rxFull,
  input  logic  cntZero,
  input  logic  tmrDone,
  input  logic  dirRead,
  output ctrl_t ctrl,
  output logic  devAck,
  output logic  rdStrobe,
  output logic  wrStrobe,
  output logic  txPop,
  output logic  rxPush,
  output logic  busy,
  output logic  done
);
  state_t state, nxt;
  logic   fifoReady;

  assign fifoReady = dirRead ? !rxFull : !txEmpty;

  always_comb begin
    nxt  = state;
    ctrl = '0;
    case (state)
      S_IDLE: if (start) begin
        nxt       = S_WREQ;
        ctrl.load = 1'b1;
      end
      S_WREQ: begin
        if (cntZero)     nxt = S_FIN;
        else if (devReq) nxt = S_ACK;
      end
      S_ACK: begin
        if (cntZero)      nxt = S_FIN;
        else if (!devReq) nxt = S_WREQ;
        else if (fifoReady) begin
          nxt           = S_STB;
          ctrl.tmrStb   = 1'b1;
          ctrl.latchOut = !dirRead;
        end
      end
      S_STB: if (tmrDone) begin
        nxt         = S_REC;
        ctrl.tmrRec = 1'b1;
        ctrl.decr   = 1'b1;
      end
      S_REC:   if (tmrDone) nxt = S_ACK;
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_FIN)                done <= 1'b1;
      else if (state == S_IDLE && start) done <= 1'b0;
    end
  end

  assign devAck   = (state == S_ACK) || (state == S_STB) || (state == S_REC);
  assign rdStrobe = (state == S_STB) && dirRead;
  assign wrStrobe = (state == S_STB) && !dirRead;
  assign txPop    = ctrl.latchOut;
  assign rxPush   = (state == S_STB) && tmrDone && dirRead;
  assign busy     = (state != S_IDLE);

  // R2: acknowledge only answers a request seen the cycle before
  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devAck) |-> $past(devReq));
  // R3: strobes live inside acknowledge, one kind at a time
  p_strobe_in_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> devAck);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));
  // R7: a new strobe needs the request high the cycle before
  p_strobe_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe || wrStrobe) |-> $past(devReq));
  // R8: FIFO gating
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);
  p_read_room_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> $past(!rxFull));
  // R9: finished transfer has released the device
  p_done_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !devAck);
endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirRead,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busy,
  output logic              done,
  input  logic              devReq,
  output logic              devAck,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              csCmdN,
  output logic              csCtlN,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEmpty,
  output logic              txPop,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxFull,
  output logic              rxPush
);
  ctrl_t ctrl;
  logic  dirLat, cntZero, tmrDone;

  mdma_fsm u_fsm (
    .clk(clk), .rstN(rstN), .start(start), .devReq(devReq),
    .txEmpty(txEmpty), .rxFull(rxFull), .cntZero(cntZero),
    .tmrDone(tmrDone), .dirRead(dirLat), .ctrl(ctrl), .devAck(devAck),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .txPop(txPop),
    .rxPush(rxPush), .busy(busy), .done(done)
  );

  mdma_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W),
    .STROBE_CYC(STROBE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wordCount(wordCount),
    .dirIn(dirRead), .txData(txData), .outData(busDataOut),
    .dirRead(dirLat), .cntZero(cntZero), .tmrDone(tmrDone)
  );

  assign csCmdN    = 1'b1;
  assign csCtlN    = 1'b1;
  assign busDataOe = devAck && !dirLat;
  assign rxData    = busDataIn;

  // R5: bus is driven only during an acknowledged write
  p_oe_only_write_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (devAck && !rdStrobe));
  // R6: a push happens only on the last cycle of a read strobe
  p_push_in_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rdStrobe);
endmodule

// File: tb/mdma_ctrl_tb.sv
module mdma_ctrl_tb;
  localparam int STB = 3;
  localparam int REC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, dirRead = 1'b0;
  logic [15:0] wordCount = '0;
  logic busy, done, devAck, rdStrobe, wrStrobe, csCmdN, csCtlN;
  logic devReq = 1'b0, rxFull = 1'b0;
  logic [15:0] busDataIn = '0;
  logic [15:0] busDataOut, txData, rxData;
  logic busDataOe, txEmpty, txPop, rxPush;

  mdma_ctrl #(.DATA_W(16), .CNT_W(16), .STROBE_CYC(STB), .RECOV_CYC(REC)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirRead(dirRead),
    .wordCount(wordCount), .busy(busy), .done(done), .devReq(devReq),
    .devAck(devAck), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .csCmdN(csCmdN), .csCtlN(csCtlN), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .txData(txData),
    .txEmpty(txEmpty), .txPop(txPop), .rxData(rxData), .rxFull(rxFull),
    .rxPush(rxPush)
  );

  logic [15:0] txMem [0:1023];
  logic [15:0] rxMem [0:1023];
  logic [15:0] devWords [0:1023];
  logic [15:0] wrLog [0:1023];
  int txRd = 0, txAvail = 0, rxN = 0, rdIdx = 0, wrN = 0;
  int strobeCnt = 0, ackRises = 0;
  int reqMode = 0, fullMode = 0;
  bit expRead = 1'b0;
  int checks = 0, errors = 0;
  int vR2 = 0, vR3 = 0, vR4 = 0, vR5 = 0, vR7 = 0, vR8 = 0;
  int bTx, bRx, bDev, bWr, bStb;

  assign txData  = txMem[txRd % 1024];
  assign txEmpty = (txRd >= txAvail);

  // local FIFO models and sampling of inputs seen at each edge
  logic sampReq = 1'b0, sampFull = 1'b0, sampEmpty = 1'b1;
  always @(posedge clk) begin
    sampReq   <= devReq;
    sampFull  <= rxFull;
    sampEmpty <= txEmpty;
    if (txPop) txRd <= txRd + 1;
    if (rxPush) begin
      rxMem[rxN % 1024] <= rxData;
      rxN <= rxN + 1;
    end
  end

  // protocol monitor and device model, away from the active edge
  logic curStb, prevStb = 1'b0, prevAck = 1'b0, prevWr = 1'b0, hadStb = 1'b0;
  int hiRun = 0, loRun = 0, dropRun = 0;
  logic [15:0] lastWr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      curStb = rdStrobe | wrStrobe;
      if (devAck && !prevAck) begin
        ackRises++;
        if (!sampReq) vR2++;
      end
      if (curStb && !devAck) vR3++;
      if (rdStrobe && wrStrobe) vR3++;
      if ((rdStrobe && !expRead) || (wrStrobe && expRead)) vR3++;
      if (!(csCmdN && csCtlN)) vR4++;
      if (busDataOe != (devAck && !expRead)) vR5++;
      if (wrStrobe) lastWr = busDataOut;
      if (curStb && !prevStb) begin
        if (!sampReq) vR7++;
        if (expRead ? sampFull : sampEmpty) vR8++;
        if (hadStb && loRun < REC + 1) vR3++;
        hadStb = 1'b1;
        hiRun  = 0;
        loRun  = 0;
      end
      if (curStb) hiRun++; else loRun++;
      if (!curStb && prevStb) begin
        if (hiRun != STB) vR3++;
        strobeCnt++;
        if (prevWr) begin
          wrLog[wrN % 1024] = lastWr;
          wrN++;
        end else rdIdx++;
      end
      if (devAck && !devReq) dropRun++; else dropRun = 0;
      if (dropRun > STB + REC + 2) vR7++;
      prevAck = devAck;
      prevStb = curStb;
      prevWr  = wrStrobe;
    end
    case (reqMode)
      0: devReq = 1'b0;
      1: devReq = 1'b1;
      default: begin
        if (!devReq) devReq = (($urandom % 3) != 0);
        else if (devAck && ($urandom % 5) == 0) devReq = 1'b0;
      end
    endcase
    case (fullMode)
      0: rxFull = 1'b0;
      1: rxFull = 1'b1;
      default: rxFull = (($urandom % 4) == 0);
    endcase
    busDataIn = devWords[rdIdx % 1024];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] genWord(input int tag, input int i);
    int v;
    v = (tag * 40503) + (i * 9973) ^ 32'h5a3c;
    return v[15:0];
  endfunction

  task automatic startXfer(input bit rd, input int n, input int tag, input int avail);
    expRead = rd;
    bTx = txRd; bRx = rxN; bDev = rdIdx; bWr = wrN; bStb = strobeCnt;
    for (int i = 0; i < n; i++) begin
      txMem[(txRd + i) % 1024]     = genWord(tag, i);
      devWords[(rdIdx + i) % 1024] = genWord(tag + 100, i);
    end
    txAvail   = txRd + avail;
    dirRead   = rd;
    wordCount = 16'(n);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R9 done cleared by start", 32'(done), 0);
  endtask

  task automatic finishXfer(input int n);
    int t = 0;
    int bad = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R9 done raised", 32'(done), 1);
    check(strobeCnt - bStb == n, "R9 strobe count", 32'(strobeCnt - bStb), 32'(n));
    check(!busy && !devAck, "R9 idle after done", {busy, devAck}, 0);
    for (int i = 0; i < n; i++) begin
      if (expRead) begin
        if (rxMem[(bRx + i) % 1024] !== devWords[(bDev + i) % 1024]) bad++;
      end else begin
        if (wrLog[(bWr + i) % 1024] !== txMem[(bTx + i) % 1024]) bad++;
      end
    end
    if (expRead) check(bad == 0, "R6 read data order", 32'(bad), 0);
    else         check(bad == 0, "R5 write data order", 32'(bad), 0);
  endtask

  initial begin
    int c0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!devAck && !rdStrobe && !wrStrobe, "R1 bus idle", {devAck, rdStrobe, wrStrobe}, 0);
    check(!busy && !done && !busDataOe, "R1 flags low", {busy, done, busDataOe}, 0);
    check(csCmdN && csCtlN, "R1 chip selects high", {csCmdN, csCtlN}, 2'b11);

    // directed write then read with steady request
    reqMode = 1;
    startXfer(1'b0, 8, 1, 8);
    finishXfer(8);
    startXfer(1'b1, 8, 2, 0);
    finishXfer(8);
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R9 done holds", 32'(done), 1);

    // R10 zero count
    c0 = ackRises;
    startXfer(1'b0, 0, 3, 0);
    finishXfer(0);
    check(ackRises == c0, "R10 no acknowledge", 32'(ackRises - c0), 0);

    // R8 transmit starvation after three words
    startXfer(1'b0, 6, 4, 3);
    repeat (80) @(negedge clk);
    check(strobeCnt - bStb == 3, "R8 strobes withheld on empty", 32'(strobeCnt - bStb), 3);
    check(busy == 1'b1, "R8 still busy while starved", 32'(busy), 1);
    txAvail = bTx + 6;
    finishXfer(6);

    // R8 receive FIFO full from the start
    fullMode = 1;
    repeat (2) @(negedge clk);
    startXfer(1'b1, 4, 5, 0);
    repeat (60) @(negedge clk);
    check(strobeCnt == bStb, "R8 strobes withheld on full", 32'(strobeCnt - bStb), 0);
    fullMode = 0;
    finishXfer(4);

    // R7 request withdrawn mid-burst, plus R9 start ignored while busy
    startXfer(1'b0, 10, 6, 10);
    while (strobeCnt - bStb < 3) @(negedge clk);
    reqMode = 0;
    repeat (STB + REC + 4) @(negedge clk);
    check(devAck == 1'b0, "R7 acknowledge dropped", 32'(devAck), 0);
    c0 = strobeCnt;
    dirRead = 1'b1; wordCount = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(strobeCnt == c0, "R7 no strobe without request", 32'(strobeCnt - c0), 0);
    reqMode = 1;
    finishXfer(10);

    // random bursts with a pausing device and a flickering receive FIFO
    reqMode = 2;
    for (int k = 0; k < 12; k++) begin
      bit rd;
      int n;
      rd = 1'($urandom % 2);
      n  = 1 + int'($urandom % 40);
      fullMode = rd ? 2 : 0;
      startXfer(rd, n, 10 + k, n);
      finishXfer(n);
    end
    reqMode = 0;
    fullMode = 0;
    repeat (5) @(negedge clk);

    check(vR2 == 0, "R2 acknowledge after request", 32'(vR2), 0);
    check(vR3 == 0, "R3 strobe shape and direction", 32'(vR3), 0);
    check(vR4 == 0, "R4 chip selects inactive", 32'(vR4), 0);
    check(vR5 == 0, "R5 output enable", 32'(vR5), 0);
    check(vR7 == 0, "R7 request pacing", 32'(vR7), 0);
    check(vR8 == 0, "R8 FIFO gating", 32'(vR8), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule